// File: doc/BRIEF.md
# Store Lane Formatter

This block sits between the store issue stage and the data write path. It takes one store request per cycle (a source register value, a byte address and a store kind) and turns it into a write for a single aligned data word. The write is made of the word-aligned address, the data already placed in its byte lanes, one enable bit per lane and the number of bytes written. It handles byte, halfword, full-word and store-conditional stores. It also handles the paired unaligned stores, store-left and store-right. For these two, the number of bytes written and the data shift both depend on the low address bits.

Lanes are numbered big-endian. Byte offset k within the word is carried on data bits `[DATA_W-1-8k -: 8]` and enabled by `o_be[k]`. A write never crosses a word boundary. All outputs are registered and appear one cycle after the request. A misaligned or unknown request is flagged with an error and enables no lanes.

Top module: `store_lane_fmt`

## Requirements
- R1: A byte store (`i_type` = 0) at offset o enables only lane o, carries `i_wdata[7:0]` in that lane and reports size 1.
- R2: A halfword store (`i_type` = 1) at an even offset o enables lanes o and o+1, which carry `i_wdata[15:8]` and `i_wdata[7:0]` in that order. It reports size 2.
- R3: A word store (`i_type` = 2) at offset 0 enables every lane, carries `i_wdata` unchanged and reports size 4.
- R4: A store-left (`i_type` = 4) at offset o enables lanes o through 3 and reports size 4−o. Lane k carries register byte k−o, where register byte 0 is the most significant byte.
- R5: A store-right (`i_type` = 5) at offset o enables lanes 0 through o and reports size 1+o. The data is `i_wdata` shifted left by 24−8·o bits.
- R6: A store-conditional (`i_type` = 3) at offset 0 writes like a word store and raises `o_cond_ok` (success = 1). `o_cond_ok` is low for every other result.
- R7: A halfword at an odd offset, a word or store-conditional at a nonzero offset, or a type code of 6 or 7 raises `o_err` with `o_be` = 0 and `o_size` = 0.
- R8: `o_addr` equals `i_addr` with its two low bits cleared.
- R9: `o_valid` follows `i_valid` by exactly one cycle. While `o_valid` is low, `o_be` is 0 and `o_err` is low.
- R10: `o_size` always equals the number of set bits in `o_be`.
- R11: While reset is asserted, `o_valid`, `o_be` and `o_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_valid | input | 1 | Request present this cycle |
| i_type | input | 3 | Store kind: 0 byte, 1 half, 2 word, 3 conditional, 4 left, 5 right |
| i_addr | input | ADDR_W | Byte address of the store |
| i_wdata | input | DATA_W | Source register value |
| o_valid | output | 1 | Result present, one cycle after the request |
| o_addr | output | ADDR_W | Word-aligned address |
| o_data | output | DATA_W | Lane-positioned write data |
| o_be | output | DATA_W/8 | Byte enables, bit k = offset k |
| o_size | output | clog2(DATA_W/8+1) | Bytes written |
| o_err | output | 1 | Misaligned or unknown store |
| o_cond_ok | output | 1 | Store-conditional success result |

## Verification
Every store kind is issued at all four offsets. This separates the shift direction and amount of the unaligned pair from the fixed placement used by byte, halfword and word stores, and it exposes the forbidden offsets of the aligned kinds. Register values have a distinct pattern in each byte, so a lane fed from the wrong source byte shows up. Requests are sent both back to back and with idle gaps between them, which tells the one-cycle valid relationship apart from a value that merely holds over from an earlier request. The unused type codes confirm that nothing is written for them.

// File: rtl/store_lane_pkg.sv
package store_lane_pkg;
   typedef enum logic [2:0] {
      SK_BYTE  = 3'd0,
      SK_HALF  = 3'd1,
      SK_WORD  = 3'd2,
      SK_COND  = 3'd3,
      SK_LEFT  = 3'd4,
      SK_RIGHT = 3'd5
   } store_kind_e;
endpackage

// File: rtl/store_lane_decode.sv
module store_lane_decode
   import store_lane_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES),
   localparam int CNT_W = $clog2(LANES + 1)
) (
   input  logic [2:0]       kind,
   input  logic [OFF_W-1:0] off,
   output logic [OFF_W-1:0] start,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] shift_bytes,
   output logic             shift_right,
   output logic             bad
);
   localparam logic [CNT_W-1:0] LANES_C = CNT_W'(LANES);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO_C   = CNT_W'(2);

   logic [CNT_W-1:0] off_c;
   assign off_c = CNT_W'(off);

   always_comb begin
      start       = '0;
      count       = '0;
      shift_bytes = '0;
      shift_right = 1'b0;
      bad         = 1'b0;
      case (kind)
         SK_BYTE: begin
            start       = off;
            count       = ONE_C;
            shift_bytes = LANES_C - ONE_C - off_c;
         end
         SK_HALF: begin
            if (off[0]) begin
               bad = 1'b1;
            end else begin
               start       = off;
               count       = TWO_C;
               shift_bytes = LANES_C - TWO_C - off_c;
            end
         end
         SK_WORD, SK_COND: begin
            if (off != '0) bad   = 1'b1;
            else           count = LANES_C;
         end
         SK_LEFT: begin
            start       = off;
            count       = LANES_C - off_c;
            shift_right = 1'b1;
            shift_bytes = off_c;
         end
         SK_RIGHT: begin
            count       = off_c + ONE_C;
            shift_bytes = LANES_C - ONE_C - off_c;
         end
         default: bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/store_lane_mask.sv
module store_lane_mask #(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES),
   localparam int CNT_W = $clog2(LANES + 1)
) (
   input  logic [OFF_W-1:0] start,
   input  logic [CNT_W-1:0] count,
   input  logic             enable,
   output logic [LANES-1:0] be
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_comb begin
         be[k] = enable && (k >= int'(start)) && (k < int'(start) + int'(count));
      end
   end
endmodule

// File: rtl/store_lane_shift.sv
module store_lane_shift #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int CNT_W = $clog2(LANES + 1)
) (
   input  logic [DATA_W-1:0] src,
   input  logic [CNT_W-1:0]  shift_bytes,
   input  logic              shift_right,
   output logic [DATA_W-1:0] dst
);
   logic [7:0] src_b [LANES];

   for (genvar j = 0; j < LANES; j++) begin : g_src
      assign src_b[j] = src[DATA_W-1-8*j -: 8];
   end

   for (genvar k = 0; k < LANES; k++) begin : g_dst
      always_comb begin
         dst[DATA_W-1-8*k -: 8] = 8'h00;
         for (int j = 0; j < LANES; j++) begin
            if (shift_right ? (j + int'(shift_bytes) == k)
                            : (k + int'(shift_bytes) == j))
               dst[DATA_W-1-8*k -: 8] = src_b[j];
         end
      end
   end
endmodule

// File: rtl/store_lane_fmt.sv
module store_lane_fmt
   import store_lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  i_valid,
   input  logic [2:0]                            i_type,
   input  logic [ADDR_W-1:0]                     i_addr,
   input  logic [DATA_W-1:0]                     i_wdata,
   output logic                                  o_valid,
   output logic [ADDR_W-1:0]                     o_addr,
   output logic [DATA_W-1:0]                     o_data,
   output logic [DATA_W/8-1:0]                   o_be,
   output logic [$clog2(DATA_W/8+1)-1:0]         o_size,
   output logic                                  o_err,
   output logic                                  o_cond_ok
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam int CNT_W = $clog2(LANES + 1);

   if (DATA_W % 8 != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
      $error("store_lane_fmt: DATA_W must be a power-of-two number of bytes, at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("store_lane_fmt: ADDR_W too small");
   end

   logic [OFF_W-1:0]  start;
   logic [CNT_W-1:0]  count;
   logic [CNT_W-1:0]  shift_bytes;
   logic              shift_right;
   logic              bad;
   logic [LANES-1:0]  be_n;
   logic [DATA_W-1:0] data_n;

   store_lane_decode #(.LANES(LANES)) dec_i (
      .kind        (i_type),
      .off         (i_addr[OFF_W-1:0]),
      .start       (start),
      .count       (count),
      .shift_bytes (shift_bytes),
      .shift_right (shift_right),
      .bad         (bad)
   );

   store_lane_mask #(.LANES(LANES)) mask_i (
      .start  (start),
      .count  (count),
      .enable (i_valid && !bad),
      .be     (be_n)
   );

   store_lane_shift #(.DATA_W(DATA_W)) shift_i (
      .src         (i_wdata),
      .shift_bytes (shift_bytes),
      .shift_right (shift_right),
      .dst         (data_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid   <= 1'b0;
         o_addr    <= '0;
         o_data    <= '0;
         o_be      <= '0;
         o_size    <= '0;
         o_err     <= 1'b0;
         o_cond_ok <= 1'b0;
      end else begin
         o_valid   <= i_valid;
         o_addr    <= {i_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
         o_data    <= data_n;
         o_be      <= be_n;
         o_size    <= (i_valid && !bad) ? count : '0;
         o_err     <= i_valid && bad;
         o_cond_ok <= i_valid && !bad && (i_type == SK_COND);
      end
   end
endmodule

// File: rtl/store_lane_fmt_chk.sv
module store_lane_fmt_chk
   import store_lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          i_valid,
   input logic [2:0]                    i_type,
   input logic                          o_valid,
   input logic [ADDR_W-1:0]             o_addr,
   input logic [DATA_W/8-1:0]           o_be,
   input logic [$clog2(DATA_W/8+1)-1:0] o_size,
   input logic                          o_err,
   input logic                          o_cond_ok
);
   localparam int OFF_W = $clog2(DATA_W / 8);

   p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      i_valid |=> o_valid);
   p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !i_valid |=> !o_valid);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !o_valid |-> (o_be == '0 && !o_err));
   p_err_no_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
      o_err |-> (o_be == '0 && o_size == '0));
   p_size_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      o_size == $bits(o_size)'($countones(o_be)));
   p_addr_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
      o_addr[OFF_W-1:0] == '0);
   p_left_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid && i_type == SK_LEFT) |=> o_be[DATA_W/8-1]);
   p_right_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid && i_type == SK_RIGHT) |=> o_be[0]);
   p_cond_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (i_type != SK_COND) |=> !o_cond_ok);
endmodule

bind store_lane_fmt store_lane_fmt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/store_lane_fmt_tb_top.sv
module store_lane_fmt_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_valid = 1'b0;
   logic [2:0]  i_type = '0;
   logic [31:0] i_addr = '0;
   logic [31:0] i_wdata = '0;
   logic        o_valid;
   logic [31:0] o_addr;
   logic [31:0] o_data;
   logic [3:0]  o_be;
   logic [2:0]  o_size;
   logic        o_err;
   logic        o_cond_ok;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] d;
      logic [3:0]  be;
      logic [2:0]  sz;
      logic        err;
      logic        cok;
   } exp_t;

   exp_t  q[$];
   string tq[$];

   always #2.5 clk = ~clk;

   store_lane_fmt dut_i (.*);

   function automatic exp_t ref_model(input logic [2:0] t, input logic [31:0] a,
                                      input logic [31:0] r);
      exp_t e;
      int o;
      logic [7:0] rb [4];
      o = int'(a[1:0]);
      for (int i = 0; i < 4; i++) rb[i] = r[31-8*i -: 8];
      e = '0;
      e.a = {a[31:2], 2'b00};
      case (t)
         3'd0: begin e.be[o] = 1'b1; e.d[31-8*o -: 8] = r[7:0]; end
         3'd1: begin
            if (o % 2 == 1) e.err = 1'b1;
            else begin
               e.be[o] = 1'b1; e.be[o+1] = 1'b1;
               e.d[31-8*o -: 8] = r[15:8]; e.d[23-8*o -: 8] = r[7:0];
            end
         end
         3'd2, 3'd3: begin
            if (o != 0) e.err = 1'b1;
            else begin e.be = 4'hF; e.d = r; e.cok = (t == 3'd3); end
         end
         3'd4: for (int k = o; k < 4; k++) begin
            e.be[k] = 1'b1; e.d[31-8*k -: 8] = rb[k-o];
         end
         3'd5: for (int k = 0; k <= o; k++) begin
            e.be[k] = 1'b1; e.d[31-8*k -: 8] = rb[3-o+k];
         end
         default: e.err = 1'b1;
      endcase
      e.sz = 3'($countones(e.be));
      return e;
   endfunction

   function automatic string tag_of(input logic [2:0] t, input exp_t e);
      if (e.err) return "R7";
      case (t)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R6";
         3'd4: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic send(input logic [2:0] t, input logic [31:0] a, input logic [31:0] r);
      exp_t e;
      @(negedge clk);
      i_valid = 1'b1; i_type = t; i_addr = a; i_wdata = r;
      e = ref_model(t, a, r);
      q.push_back(e);
      tq.push_back(tag_of(t, e));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         i_valid = 1'b0; i_type = 3'd7; i_addr = 32'hFFFF_FFFF; i_wdata = 32'hDEAD_BEEF;
      end
   endtask

   // scoreboard monitor
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (o_valid) begin
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL R9: unexpected o_valid, actual 1 expected 0");
            end else begin
               exp_t  e;
               string tg;
               logic [31:0] m;
               e  = q.pop_front();
               tg = tq.pop_front();
               m  = {{8{e.be[0]}}, {8{e.be[1]}}, {8{e.be[2]}}, {8{e.be[3]}}};
               if (o_be !== e.be || o_size !== e.sz || o_err !== e.err ||
                   o_cond_ok !== e.cok || (o_data & m) !== (e.d & m)) begin
                  errors++;
                  $display("FAIL %s: actual be=%h sz=%0d err=%b cok=%b data=%h expected be=%h sz=%0d err=%b cok=%b data=%h",
                           tg, o_be, o_size, o_err, o_cond_ok, o_data & m,
                           e.be, e.sz, e.err, e.cok, e.d & m);
               end
               checks++;
               if (o_addr !== e.a) begin
                  errors++;
                  $display("FAIL R8: actual addr=%h expected %h", o_addr, e.a);
               end
            end
         end else begin
            checks++;
            if (o_be !== 4'h0 || o_err !== 1'b0) begin
               errors++;
               $display("FAIL R9: idle actual be=%h err=%b expected be=0 err=0", o_be, o_err);
            end
         end
      end
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] regs [3];
      regs[0] = 32'h1122_3344;
      regs[1] = 32'hA5C3_0F96;
      regs[2] = 32'h80FF_017E;
      repeat (3) @(negedge clk);
      checks++;   // R11 reset state
      if (o_valid !== 1'b0 || o_be !== 4'h0 || o_err !== 1'b0) begin
         errors++;
         $display("FAIL R11: actual valid=%b be=%h err=%b expected 0 0 0", o_valid, o_be, o_err);
      end
      rst_n = 1'b1;
      idle(2);
      // every kind at every offset, back to back
      for (int t = 0; t < 8; t++)
         for (int o = 0; o < 4; o++)
            send(3'(t), 32'h0000_1000 + 32'(o) + 32'(t * 16), regs[t % 3]);
      idle(3);
      // gapped requests, different register values
      for (int o = 0; o < 4; o++) begin
         send(3'd4, 32'hABCD_EF00 + 32'(o), regs[(o + 1) % 3]);
         idle(1);
         send(3'd5, 32'h7654_3210 + 32'(o), regs[o % 3]);
         idle(2);
      end
      send(3'd3, 32'h0000_0040, 32'h0000_0000);
      send(3'd0, 32'hFFFF_FFFF, 32'h0000_00AB);
      send(3'd1, 32'h0000_0002, 32'h0000_CAFE);
      idle(4);
      checks++;   // R9 every request produced one result
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R9: actual %0d pending results expected 0", q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule